// File: doc/BRIEF.md
# Overshoot Threshold Arming Controller

This block decides when the fast-overshoot response of a digital voltage regulation loop is allowed to fire. Software programs an entry threshold. The block keeps it in a shadow register and drives a separate live threshold register. The live value is held at zero while the converter is off and during soft-start. It is loaded from the shadow when the output first reaches its target, and it drops back to zero when the converter is switched off. A zero live threshold means the mode is disarmed.

A second part of the block filters the sensed output voltage through a first-order low-pass filter with a selectable corner. It compares the result with the reference plus the live threshold and raises an overshoot flag. The flag stays high until the filtered voltage falls below the reference plus a smaller exit threshold. Writes to the thresholds are accepted at any time. While regulating, an entry write takes effect at once, so the response can be tuned live.

Top module: `ovs_arm_ctrl`

## Requirements
- R1: While reset is low, the live threshold is 0, the shadow takes the value on `boot_thr`, the exit threshold takes `EXIT_RST`, the flag is 0, `regulating` is 0 and the filter output is 0.
- R2: While the converter is disabled or ramping (`regulating` = 0), the live threshold reads 0.
- R3: The first `tgt_hit` pulse while ramping sets `regulating` and copies the shadow into the live threshold at the next clock edge.
- R4: A `tgt_hit` pulse while disabled or already regulating has no effect on `regulating` or on the live threshold.
- R5: At the clock edge after `conv_en` is seen low, the live threshold is 0 and `regulating` is 0. The shadow keeps its value.
- R6: While regulating, a write with `wr_sel` = 0 loads `wr_data` into both the shadow and the live threshold at the next edge.
- R7: While disabled or ramping, a write with `wr_sel` = 0 loads only the shadow.
- R8: If an entry write and the restoring `tgt_hit` pulse occur in the same cycle, the live threshold takes the written value.
- R9: With a non-zero live threshold, the flag sets two edges after a `vsen` sample whose filtered value is strictly greater than `vref` plus the live threshold.
- R10: Once set, the flag stays high until the filtered value is strictly below `vref` plus the exit threshold. It clears at the edge after that happens.
- R11: The flag is 0 at the edge after any cycle in which the live threshold is 0.
- R12: With `lpf_sel` = k (0..3), the filter updates each edge as y <= y + ((vsen - y) >>> k). With k = 0 the filter passes the sample after one edge.
- R13: A write with `wr_sel` = 1 loads the exit threshold at the next edge, in any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_thr | input | TW | Programmed entry threshold captured at reset |
| conv_en | input | 1 | Converter enable |
| tgt_hit | input | 1 | Single-cycle pulse: output reached its initial target |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 entry threshold, 1 exit threshold |
| wr_data | input | TW | Write data |
| lpf_sel | input | 2 | Filter shift k; 0 bypasses smoothing |
| vref | input | VW | Voltage reference |
| vsen | input | VW | Sensed voltage sample |
| act_thr | output | TW | Live entry threshold |
| shd_thr | output | TW | Shadow entry threshold |
| vfilt | output | VW | Filtered sensed voltage |
| regulating | output | 1 | Target reached since the last enable |
| ovs_active | output | 1 | Overshoot flag |

## Verification
State updates for arming, restoring, disarming and register writes are due one edge after the stimulus. The flag is due two edges after a `vsen` sample, one edge for the filter register and one for the flag register. The filter output moves one step per edge. The vector walk applies each row at a falling edge, clears the pulses after one cycle and compares all outputs three falling edges later, when every result has settled. Directed tests then sample at the exact falling edge where each one-edge or two-edge result first becomes due, and also one edge earlier for the flag.

// File: rtl/ovs_arm_pkg.sv
// Package: shared state encoding for the overshoot arming controller.
package ovs_arm_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RAMP = 2'd1,
        ST_REG  = 2'd2
    } arm_state_t;
endpackage

// File: rtl/ovs_arm_fsm.sv
// Module: arming sequencer. Tracks off / soft-start / regulating.
// Assumes tgt_hit is a single-cycle pulse; only the first one after each
// enable moves the sequencer to regulating.
module ovs_arm_fsm
    import ovs_arm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       conv_en,
    input  logic       tgt_hit,
    output arm_state_t state,
    output logic       restore
);
    arm_state_t state_nx;

    // Restore strobe: first target pulse while ramping.
    assign restore = (state == ST_RAMP) && conv_en && tgt_hit;

    // Next-state selection.
    always_comb begin
        state_nx = state;
        if (!conv_en) begin
            state_nx = ST_OFF;
        end else begin
            case (state)
                ST_OFF:  state_nx = ST_RAMP;
                ST_RAMP: if (tgt_hit) state_nx = ST_REG;
                default: state_nx = ST_REG;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end
endmodule

// File: rtl/ovs_thr_regs.sv
// Module: threshold storage. Shadow entry threshold, live entry threshold
// and exit threshold. The live value is zero unless regulating. Assumes
// restore and state come from the arming sequencer.
module ovs_thr_regs
    import ovs_arm_pkg::*;
#(
    parameter int TW       = 8,
    parameter int EXIT_RST = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] boot_thr,
    input  logic          conv_en,
    input  arm_state_t    state,
    input  logic          restore,
    input  logic          wr_en,
    input  logic          wr_sel,
    input  logic [TW-1:0] wr_data,
    output logic [TW-1:0] shd_thr,
    output logic [TW-1:0] act_thr,
    output logic [TW-1:0] exit_thr
);
    logic          wr_entry;
    logic          wr_exit;
    logic [TW-1:0] shd_nx;
    logic [TW-1:0] act_nx;

    assign wr_entry = wr_en && !wr_sel;
    assign wr_exit  = wr_en &&  wr_sel;

    // Shadow next value: any entry write lands here.
    assign shd_nx = wr_entry ? wr_data : shd_thr;

    // Live next value: cleared when off, restored once, tuned while regulating.
    always_comb begin
        if (!conv_en)
            act_nx = '0;
        else if (restore)
            act_nx = shd_nx;
        else if (state == ST_REG && wr_entry)
            act_nx = wr_data;
        else
            act_nx = act_thr;
    end

    // Threshold registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shd_thr  <= boot_thr;
            act_thr  <= '0;
            exit_thr <= TW'(EXIT_RST);
        end else begin
            shd_thr  <= shd_nx;
            act_thr  <= act_nx;
            if (wr_exit) exit_thr <= wr_data;
        end
    end
endmodule

// File: rtl/ovs_lpf.sv
// Module: first-order low-pass filter, y += (x - y) >>> k, k picked at run
// time. k = 0 gives a one-cycle registered pass-through. Assumes unsigned
// samples.
module ovs_lpf #(
    parameter int VW = 12,
    parameter int KW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [KW-1:0] k_sel,
    input  logic [VW-1:0] x_in,
    output logic [VW-1:0] y_out
);
    logic signed [VW:0] diff;
    logic signed [VW:0] step;

    // Signed error term and its scaled step.
    always_comb begin
        diff = $signed({1'b0, x_in}) - $signed({1'b0, y_out});
        step = diff >>> k_sel;
    end

    // Filter state register.
    always_ff @(posedge clk) begin
        if (!rst_n) y_out <= '0;
        else        y_out <= y_out + step[VW-1:0];
    end
endmodule

// File: rtl/ovs_detect.sv
// Module: overshoot flag with hysteresis. Sets above vref + entry threshold,
// clears below vref + exit threshold. A zero entry threshold disarms it.
// Assumes exit threshold is programmed smaller than the entry one.
module ovs_detect #(
    parameter int VW = 12,
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [VW-1:0] vfilt,
    input  logic [VW-1:0] vref,
    input  logic [TW-1:0] act_thr,
    input  logic [TW-1:0] exit_thr,
    output logic          flag
);
    localparam int SW = VW + 1;

    logic [SW-1:0] lvl_hi;
    logic [SW-1:0] lvl_lo;
    logic          above;
    logic          below;
    logic          armed;

    // Comparison levels with one guard bit.
    always_comb begin
        lvl_hi = SW'(vref) + SW'(act_thr);
        lvl_lo = SW'(vref) + SW'(exit_thr);
        above  = SW'(vfilt) > lvl_hi;
        below  = SW'(vfilt) < lvl_lo;
        armed  = act_thr != '0;
    end

    // Flag register with hysteresis.
    always_ff @(posedge clk) begin
        if (!rst_n)      flag <= 1'b0;
        else if (!armed) flag <= 1'b0;
        else if (!flag)  flag <= above;
        else             flag <= !below;
    end
endmodule

// File: rtl/ovs_arm_ctrl.sv
// Module: top of the overshoot threshold arming controller. Keeps the mode
// disarmed through soft-start, restores the programmed threshold at the
// first target pulse and flags overshoot on the filtered sensed voltage.
// Assumes all inputs are synchronous to clk.
module ovs_arm_ctrl
    import ovs_arm_pkg::*;
#(
    parameter int VW       = 12,
    parameter int TW       = 8,
    parameter int EXIT_RST = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] boot_thr,
    input  logic          conv_en,
    input  logic          tgt_hit,
    input  logic          wr_en,
    input  logic          wr_sel,
    input  logic [TW-1:0] wr_data,
    input  logic [1:0]    lpf_sel,
    input  logic [VW-1:0] vref,
    input  logic [VW-1:0] vsen,
    output logic [TW-1:0] act_thr,
    output logic [TW-1:0] shd_thr,
    output logic [VW-1:0] vfilt,
    output logic          regulating,
    output logic          ovs_active
);
    arm_state_t    state;
    logic          restore;
    logic [TW-1:0] exit_thr;

    assign regulating = (state == ST_REG);

    ovs_arm_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .conv_en (conv_en),
        .tgt_hit (tgt_hit),
        .state   (state),
        .restore (restore)
    );

    ovs_thr_regs #(.TW(TW), .EXIT_RST(EXIT_RST)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .boot_thr (boot_thr),
        .conv_en  (conv_en),
        .state    (state),
        .restore  (restore),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .shd_thr  (shd_thr),
        .act_thr  (act_thr),
        .exit_thr (exit_thr)
    );

    ovs_lpf #(.VW(VW), .KW(2)) u_lpf (
        .clk   (clk),
        .rst_n (rst_n),
        .k_sel (lpf_sel),
        .x_in  (vsen),
        .y_out (vfilt)
    );

    ovs_detect #(.VW(VW), .TW(TW)) u_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .vfilt    (vfilt),
        .vref     (vref),
        .act_thr  (act_thr),
        .exit_thr (exit_thr),
        .flag     (ovs_active)
    );
endmodule

// File: rtl/ovs_arm_chk.sv
// Checker: temporal properties of the arming controller, bound to the top.
module ovs_arm_chk #(
    parameter int TW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          conv_en,
    input logic          wr_en,
    input logic          wr_sel,
    input logic [TW-1:0] wr_data,
    input logic [TW-1:0] act_thr,
    input logic [TW-1:0] shd_thr,
    input logic          regulating,
    input logic          ovs_active
);
    // R2
    live_zero_unarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !regulating |-> act_thr == '0);

    // R5
    disable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_en |=> (act_thr == '0 && !regulating));

    // R3
    restore_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(regulating) |-> act_thr == shd_thr);

    // R6
    live_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (regulating && conv_en && wr_en && !wr_sel) |=> act_thr == $past(wr_data));

    // R11
    disarmed_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_thr == '0 |=> !ovs_active);
endmodule

bind ovs_arm_ctrl ovs_arm_chk #(.TW(TW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_en    (conv_en),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .act_thr    (act_thr),
    .shd_thr    (shd_thr),
    .regulating (regulating),
    .ovs_active (ovs_active)
);

// File: tb/ovs_arm_ctrl_bench.sv
module ovs_arm_ctrl_bench;
    localparam int VW = 12;
    localparam int TW = 8;
    localparam int NROW = 17;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [TW-1:0] boot_thr = 8'd40;
    logic          conv_en = 1'b0;
    logic          tgt_hit = 1'b0;
    logic          wr_en = 1'b0;
    logic          wr_sel = 1'b0;
    logic [TW-1:0] wr_data = '0;
    logic [1:0]    lpf_sel = 2'd0;
    logic [VW-1:0] vref = 12'd2000;
    logic [VW-1:0] vsen = 12'd0;
    logic [TW-1:0] act_thr;
    logic [TW-1:0] shd_thr;
    logic [VW-1:0] vfilt;
    logic          regulating;
    logic          ovs_active;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    ovs_arm_ctrl #(.VW(VW), .TW(TW), .EXIT_RST(10)) u_ovs_arm_ctrl (
        .clk(clk), .rst_n(rst_n), .boot_thr(boot_thr), .conv_en(conv_en),
        .tgt_hit(tgt_hit), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .lpf_sel(lpf_sel), .vref(vref), .vsen(vsen), .act_thr(act_thr),
        .shd_thr(shd_thr), .vfilt(vfilt), .regulating(regulating),
        .ovs_active(ovs_active)
    );

    task automatic chk(input string req, input int actual, input int expected);
        checks++;
        if (actual !== expected) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    // Row: en tgt wr sel data[8] vsen[12] exp_act[8] exp_shd[8] flag reg
    localparam logic [41:0] TBL [NROW] = '{
        {1'b0,1'b0,1'b0,1'b0, 8'd0,  12'd2000, 8'd0,   8'd40,  1'b0,1'b0}, // R2
        {1'b0,1'b0,1'b1,1'b0, 8'd60, 12'd2000, 8'd0,   8'd60,  1'b0,1'b0}, // R7 off
        {1'b1,1'b0,1'b0,1'b0, 8'd0,  12'd2100, 8'd0,   8'd60,  1'b0,1'b0}, // R11 ramp
        {1'b1,1'b0,1'b1,1'b0, 8'd50, 12'd2100, 8'd0,   8'd50,  1'b0,1'b0}, // R7 ramp
        {1'b1,1'b1,1'b0,1'b0, 8'd0,  12'd2100, 8'd50,  8'd50,  1'b1,1'b1}, // R3 R9
        {1'b1,1'b0,1'b0,1'b0, 8'd0,  12'd2030, 8'd50,  8'd50,  1'b1,1'b1}, // R10 band
        {1'b1,1'b0,1'b0,1'b0, 8'd0,  12'd2009, 8'd50,  8'd50,  1'b0,1'b1}, // R10 clear
        {1'b1,1'b0,1'b0,1'b0, 8'd0,  12'd2050, 8'd50,  8'd50,  1'b0,1'b1}, // R9 equal
        {1'b1,1'b0,1'b0,1'b0, 8'd0,  12'd2051, 8'd50,  8'd50,  1'b1,1'b1}, // R9 above
        {1'b1,1'b0,1'b1,1'b0, 8'd100,12'd2051, 8'd100, 8'd100, 1'b1,1'b1}, // R6
        {1'b1,1'b1,1'b0,1'b0, 8'd0,  12'd2000, 8'd100, 8'd100, 1'b0,1'b1}, // R4 reg
        {1'b1,1'b0,1'b1,1'b1, 8'd60, 12'd2055, 8'd100, 8'd100, 1'b0,1'b1}, // R13
        {1'b1,1'b0,1'b0,1'b0, 8'd0,  12'd2101, 8'd100, 8'd100, 1'b1,1'b1}, // R9
        {1'b1,1'b0,1'b0,1'b0, 8'd0,  12'd2059, 8'd100, 8'd100, 1'b0,1'b1}, // R13 exit
        {1'b0,1'b0,1'b0,1'b0, 8'd0,  12'd2200, 8'd0,   8'd100, 1'b0,1'b0}, // R5 R11
        {1'b0,1'b1,1'b0,1'b0, 8'd0,  12'd2000, 8'd0,   8'd100, 1'b0,1'b0}, // R4 off
        {1'b1,1'b0,1'b0,1'b0, 8'd0,  12'd2000, 8'd0,   8'd100, 1'b0,1'b0}  // R4 no carry
    };

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 act", int'(act_thr), 0);
        chk("R1 shd", int'(shd_thr), 40);
        chk("R1 flag", int'(ovs_active), 0);
        chk("R1 reg", int'(regulating), 0);
        chk("R1 vfilt", int'(vfilt), 0);
        rst_n = 1'b1;

        // R12 filter steps with k=1, vsen=1000
        lpf_sel = 2'd1; vsen = 12'd1000;
        @(negedge clk); chk("R12 step1", int'(vfilt), 500);
        @(negedge clk); chk("R12 step2", int'(vfilt), 750);
        @(negedge clk); chk("R12 step3", int'(vfilt), 875);
        lpf_sel = 2'd0;
        @(negedge clk); chk("R12 k0 pass", int'(vfilt), 1000);

        // Vector walk
        for (int i = 0; i < NROW; i++) begin
            logic [41:0] r;
            r = TBL[i];
            conv_en = r[41]; tgt_hit = r[40]; wr_en = r[39]; wr_sel = r[38];
            wr_data = r[37:30]; vsen = r[29:18];
            @(negedge clk);
            tgt_hit = 1'b0; wr_en = 1'b0;
            repeat (2) @(negedge clk);
            chk($sformatf("row%0d act", i), int'(act_thr), int'(r[17:10]));
            chk($sformatf("row%0d shd", i), int'(shd_thr), int'(r[9:2]));
            chk($sformatf("row%0d flag", i), int'(ovs_active), int'(r[1]));
            chk($sformatf("row%0d reg", i), int'(regulating), int'(r[0]));
        end

        // R8: entry write and restore pulse in the same cycle (ramping now)
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = 8'd77; tgt_hit = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tgt_hit = 1'b0;
        chk("R8 act", int'(act_thr), 77);
        chk("R3 reg one edge", int'(regulating), 1);

        // R9 two-edge latency: 2100 > 2077
        vsen = 12'd2100;
        @(negedge clk); chk("R9 flag edge1", int'(ovs_active), 0);
        @(negedge clk); chk("R9 flag edge2", int'(ovs_active), 1);

        // R6 one-edge latency
        wr_en = 1'b1; wr_data = 8'd90;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R6 act edge1", int'(act_thr), 90);

        // R5 one-edge latency, shadow kept
        conv_en = 1'b0;
        @(negedge clk);
        chk("R5 act edge1", int'(act_thr), 0);
        chk("R5 reg edge1", int'(regulating), 0);
        chk("R5 shd kept", int'(shd_thr), 90);
        @(negedge clk);
        chk("R11 flag cleared", int'(ovs_active), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule